// File: doc/BRIEF.md
# Sequence-Number Squash Walker

The block cleans an in-flight instruction window after a misprediction or similar event. A squash request carries a boundary sequence number and the index of the youngest allocated entry. Starting there, the walker reads one window entry per clock and moves toward older entries, wrapping from index 0 to the highest index. It keeps going while the entry it reads is allocated and carries a sequence number greater than the boundary.

Each younger entry that has not issued and is not already squashed is cleaned. For an ordinary entry, the walker asks the dependency storage to drop each pending source wait and tells the window to mark the entry squashed. The same notice puts the entry's index on the squashed list so that it can drain later. A nonspeculative or store entry never registered source waits. Instead of cancelling them, the walker removes that entry's sequence number from the table that holds nonspeculative work. An external stop command aborts a walk at any time.

Three running counters record the walk's effort: entries examined, source operands examined and nonspeculative entries removed.

Top module: `squash_walker`

## Requirements
- R1: After reset the following are all zero: `busy`, `done`, `pushValid`, `nsRemValid`, `cancelValid` and all three counters.
- R2: A `squashReq` received while idle that carries a nonzero `squashSeq` starts a walk. `busy` is high from the next cycle, and in that first cycle `rdIdx` equals the `tailIdx` captured with the request. A request with a zero boundary, or one that arrives during a walk, has no effect.
- R3: While busy, the walk presents one entry per cycle on `rdIdx` and decrements it each cycle, wrapping from index 0 to DEPTH-1. One walk examines at most DEPTH entries.
- R4: The walk ends at the first entry that is unallocated, or whose sequence number is not greater than the boundary, or that would start a second lap. In that cycle no output strobe is raised. `busy` falls in the next cycle, and `done` is high for exactly that one cycle.
- R5: A younger entry flagged as issued or as already squashed is stepped over. It raises no push, no cancel and no removal, but it still counts as examined.
- R6: A younger ordinary entry that is acted on raises `pushValid` with `pushIdx` equal to the entry index; the window sets its squashed flag from this strobe. Source s raises `cancelValid[s]` with `cancelTags[s*TAG_W +: TAG_W]` equal to its tag when three conditions all hold: the source is valid, it is not ready, and its tag is below PHYS_REGS.
- R7: A younger nonspeculative or store entry that is acted on raises `pushValid` and `nsRemValid`, with `nsRemSeq` equal to the entry's sequence number. It raises no `cancelValid` bit.
- R8: While `stopSquash` is high, no output strobe is raised. In the next cycle `busy` is low and `done` stays low. `stopSquash` takes priority over a simultaneous request, and the next valid request starts normally.
- R9: The counters wrap at 2^CNT_W. `cntExamined` grows by one for each younger entry stepped past. `cntOperands` grows by the number of valid sources of each ordinary entry acted on. `cntNsRemoved` grows by one for each removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| squashReq | input | 1 | Start a walk |
| squashSeq | input | SEQ_W | Boundary sequence number |
| tailIdx | input | IDX_W | Index of the youngest allocated entry |
| stopSquash | input | 1 | Abort the walk and clear the boundary |
| rdIdx | output | IDX_W | Window entry being read |
| entValid | input | 1 | Entry at rdIdx is allocated |
| entSeq | input | SEQ_W | Sequence number of the entry |
| entIssued | input | 1 | Entry already issued |
| entSquashed | input | 1 | Entry already squashed |
| entNonSpec | input | 1 | Entry is nonspeculative or a store |
| entSrcValid | input | NSRC | Source slot used |
| entSrcReady | input | NSRC | Source already ready |
| entSrcTags | input | NSRC*TAG_W | Physical tags of the sources |
| cancelValid | output | NSRC | Cancel the wait of source s |
| cancelTags | output | NSRC*TAG_W | Tags for the cancels |
| pushValid | output | 1 | Mark squashed and push onto the squashed list |
| pushIdx | output | IDX_W | Entry index pushed |
| nsRemValid | output | 1 | Remove from the nonspeculative table |
| nsRemSeq | output | SEQ_W | Sequence number to remove |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| cntExamined | output | CNT_W | Entries examined |
| cntOperands | output | CNT_W | Source operands examined |
| cntNsRemoved | output | CNT_W | Nonspeculative entries removed |

## Verification
The assertions assume that the window answers `rdIdx` combinationally in the same cycle. They also assume that an entry's issued and squashed flags do not change while the walker is reading it. In the bench, the window model is a set of arrays indexed by `rdIdx`. The bench applies squashed flags only after a walk has finished, which is safe because a single walk visits each index at most once. The bench sweeps the boundary across every position of partly and fully occupied windows at several head offsets, then repeats each walk over the same window so that it steps over entries already squashed.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef struct packed {
    logic active;
    logic load;
    logic step;
    logic park;
  } sqwStrobes_t;
endpackage

// File: rtl/sqw_ctrl.sv
module sqw_ctrl
  import sqw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        squashReq,
  input  logic        seqNonZero,
  input  logic        stopSquash,
  input  logic        inRange,
  output sqwStrobes_t strb,
  output logic        busy,
  output logic        done
);
  logic busyQ, doneQ;

  always_comb begin
    strb.active = busyQ && !stopSquash;
    strb.load   = !stopSquash && !busyQ && squashReq && seqNonZero;
    strb.step   = strb.active && inRange;
    strb.park   = stopSquash || (busyQ && !inRange);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (stopSquash) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (strb.load) begin
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (busyQ && !inRange) begin
      busyQ <= 1'b0;
      doneQ <= 1'b1;
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/sqw_datapath.sv
module sqw_datapath
  import sqw_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int NSRC      = 2,
  parameter int TAG_W     = 6,
  parameter int PHYS_REGS = 40,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sqwStrobes_t           strb,
  input  logic [SEQ_W-1:0]      squashSeq,
  input  logic [IDX_W-1:0]      tailIdx,
  output logic [IDX_W-1:0]      rdIdx,
  input  logic                  entValid,
  input  logic [SEQ_W-1:0]      entSeq,
  input  logic                  entIssued,
  input  logic                  entSquashed,
  input  logic                  entNonSpec,
  input  logic [NSRC-1:0]       entSrcValid,
  input  logic [NSRC-1:0]       entSrcReady,
  input  logic [NSRC*TAG_W-1:0] entSrcTags,
  output logic                  inRange,
  output logic [NSRC-1:0]       cancelValid,
  output logic [NSRC*TAG_W-1:0] cancelTags,
  output logic                  pushValid,
  output logic [IDX_W-1:0]      pushIdx,
  output logic                  nsRemValid,
  output logic [SEQ_W-1:0]      nsRemSeq,
  output logic [CNT_W-1:0]      cntExamined,
  output logic [CNT_W-1:0]      cntOperands,
  output logic [CNT_W-1:0]      cntNsRemoved
);
  localparam logic [TAG_W:0]   TAG_LIMIT = (TAG_W+1)'(PHYS_REGS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr, startIdx, ptrNext;
  logic             ptrValid, lapDone;
  logic [SEQ_W-1:0] boundary;
  logic             actOn;
  logic [CNT_W-1:0] opsThis;

  assign ptrNext = (ptr == '0) ? LAST_IDX : ptr - IDX_W'(1);
  assign rdIdx   = ptr;
  assign inRange = ptrValid && !lapDone && entValid && (entSeq > boundary);
  assign actOn   = strb.active && inRange && !entIssued && !entSquashed;

  assign pushValid  = actOn;
  assign pushIdx    = ptr;
  assign nsRemValid = actOn && entNonSpec;
  assign nsRemSeq   = entSeq;
  assign cancelTags = entSrcTags;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [TAG_W-1:0] srcTag;
    assign srcTag = entSrcTags[s*TAG_W +: TAG_W];
    assign cancelValid[s] = actOn && !entNonSpec && entSrcValid[s] &&
                            !entSrcReady[s] && ({1'b0, srcTag} < TAG_LIMIT);
  end

  always_comb begin
    opsThis = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (actOn && !entNonSpec && entSrcValid[s]) opsThis = opsThis + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr          <= '0;
      startIdx     <= '0;
      ptrValid     <= 1'b0;
      lapDone      <= 1'b0;
      boundary     <= '0;
      cntExamined  <= '0;
      cntOperands  <= '0;
      cntNsRemoved <= '0;
    end else if (strb.park) begin
      ptrValid <= 1'b0;
      boundary <= '0;
    end else if (strb.load) begin
      ptr      <= tailIdx;
      startIdx <= tailIdx;
      ptrValid <= 1'b1;
      lapDone  <= 1'b0;
      boundary <= squashSeq;
    end else if (strb.step) begin
      ptr          <= ptrNext;
      lapDone      <= (ptrNext == startIdx);
      cntExamined  <= cntExamined + CNT_W'(1);
      cntOperands  <= cntOperands + opsThis;
      cntNsRemoved <= cntNsRemoved + CNT_W'(nsRemValid);
    end
  end
endmodule

// File: rtl/squash_walker.sv
module squash_walker
  import sqw_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int NSRC      = 2,
  parameter int TAG_W     = 6,
  parameter int PHYS_REGS = 40,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  squashReq,
  input  logic [SEQ_W-1:0]      squashSeq,
  input  logic [IDX_W-1:0]      tailIdx,
  input  logic                  stopSquash,
  output logic [IDX_W-1:0]      rdIdx,
  input  logic                  entValid,
  input  logic [SEQ_W-1:0]      entSeq,
  input  logic                  entIssued,
  input  logic                  entSquashed,
  input  logic                  entNonSpec,
  input  logic [NSRC-1:0]       entSrcValid,
  input  logic [NSRC-1:0]       entSrcReady,
  input  logic [NSRC*TAG_W-1:0] entSrcTags,
  output logic [NSRC-1:0]       cancelValid,
  output logic [NSRC*TAG_W-1:0] cancelTags,
  output logic                  pushValid,
  output logic [IDX_W-1:0]      pushIdx,
  output logic                  nsRemValid,
  output logic [SEQ_W-1:0]      nsRemSeq,
  output logic                  busy,
  output logic                  done,
  output logic [CNT_W-1:0]      cntExamined,
  output logic [CNT_W-1:0]      cntOperands,
  output logic [CNT_W-1:0]      cntNsRemoved
);
  sqwStrobes_t strb;
  logic        inRange;

  sqw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .squashReq  (squashReq),
    .seqNonZero (|squashSeq),
    .stopSquash (stopSquash),
    .inRange    (inRange),
    .strb       (strb),
    .busy       (busy),
    .done       (done)
  );

  sqw_datapath #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .NSRC(NSRC), .TAG_W(TAG_W),
    .PHYS_REGS(PHYS_REGS), .CNT_W(CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .squashSeq    (squashSeq),
    .tailIdx      (tailIdx),
    .rdIdx        (rdIdx),
    .entValid     (entValid),
    .entSeq       (entSeq),
    .entIssued    (entIssued),
    .entSquashed  (entSquashed),
    .entNonSpec   (entNonSpec),
    .entSrcValid  (entSrcValid),
    .entSrcReady  (entSrcReady),
    .entSrcTags   (entSrcTags),
    .inRange      (inRange),
    .cancelValid  (cancelValid),
    .cancelTags   (cancelTags),
    .pushValid    (pushValid),
    .pushIdx      (pushIdx),
    .nsRemValid   (nsRemValid),
    .nsRemSeq     (nsRemSeq),
    .cntExamined  (cntExamined),
    .cntOperands  (cntOperands),
    .cntNsRemoved (cntNsRemoved)
  );
endmodule

// File: rtl/squash_walker_chk.sv
module squash_walker_chk #(
  parameter int DEPTH     = 8,
  parameter int NSRC      = 2,
  parameter int TAG_W     = 6,
  parameter int PHYS_REGS = 40,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stopSquash,
  input logic [IDX_W-1:0]      rdIdx,
  input logic                  entIssued,
  input logic                  entSquashed,
  input logic                  entNonSpec,
  input logic [NSRC-1:0]       cancelValid,
  input logic [NSRC*TAG_W-1:0] cancelTags,
  input logic                  pushValid,
  input logic                  nsRemValid,
  input logic                  busy,
  input logic                  done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  AST_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid || nsRemValid || (|cancelValid)) |-> busy); // R4

  AST_SKIP_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (entIssued || entSquashed) |-> (!pushValid && !nsRemValid && cancelValid == '0)); // R5

  AST_CANCEL_HAS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (|cancelValid) |-> (pushValid && !entNonSpec)); // R6

  AST_NSREM_NO_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    nsRemValid |-> (pushValid && cancelValid == '0)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4

  AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R4

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    stopSquash |=> (!busy && !done)); // R8

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stopSquash |-> (!pushValid && !nsRemValid && cancelValid == '0)); // R8

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |->
      (rdIdx == (($past(rdIdx) == '0) ? LAST_IDX : $past(rdIdx) - IDX_W'(1)))); // R3

  for (genvar s = 0; s < NSRC; s++) begin : g_rng
    AST_CANCEL_TAG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      cancelValid[s] |-> (int'(cancelTags[s*TAG_W +: TAG_W]) < PHYS_REGS)); // R6
  end
endmodule

bind squash_walker squash_walker_chk #(
  .DEPTH(DEPTH), .NSRC(NSRC), .TAG_W(TAG_W), .PHYS_REGS(PHYS_REGS)
) u_chk (.*);

// File: tb/test_squash_walker.sv
`timescale 1ns/1ps
module test_squash_walker;
  localparam int DEPTH = 8, SEQ_W = 16, NSRC = 2, TAG_W = 6, PHYS = 40, CNT_W = 16;
  localparam int IDX_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic squashReq = 1'b0, stopSquash = 1'b0;
  logic [SEQ_W-1:0] squashSeq = '0;
  logic [IDX_W-1:0] tailIdx = '0, rdIdx, pushIdx;
  logic entValid, entIssued, entSquashed, entNonSpec;
  logic [SEQ_W-1:0] entSeq, nsRemSeq;
  logic [NSRC-1:0] entSrcValid, entSrcReady, cancelValid;
  logic [NSRC*TAG_W-1:0] entSrcTags, cancelTags;
  logic pushValid, nsRemValid, busy, done;
  logic [CNT_W-1:0] cntExamined, cntOperands, cntNsRemoved;

  logic [SEQ_W-1:0] wSeq [DEPTH];
  logic wValid [DEPTH], wIss [DEPTH], wSq [DEPTH], wNs [DEPTH];
  logic [1:0] wSrcV [DEPTH], wSrcR [DEPTH];
  logic [11:0] wTags [DEPTH];

  assign entValid    = wValid[rdIdx];
  assign entSeq      = wSeq[rdIdx];
  assign entIssued   = wIss[rdIdx];
  assign entSquashed = wSq[rdIdx];
  assign entNonSpec  = wNs[rdIdx];
  assign entSrcValid = wSrcV[rdIdx];
  assign entSrcReady = wSrcR[rdIdx];
  assign entSrcTags  = wTags[rdIdx];

  always #2.5 clk = ~clk;

  squash_walker i_squash_walker (.*);

  int total = 0, bad = 0;
  int expExam = 0, expOps = 0, expNs = 0;

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic fill(int head, int count, int pat);
    for (int i = 0; i < DEPTH; i++) begin
      wValid[i] = 1'b0; wSeq[i] = '0; wIss[i] = 1'b0; wSq[i] = 1'b0; wNs[i] = 1'b0;
      wSrcV[i] = '0; wSrcR[i] = '0; wTags[i] = '0;
    end
    for (int i = 0; i < count; i++) begin
      int k = (head + i) % DEPTH;
      wValid[k] = 1'b1;
      wSeq[k]   = SEQ_W'(10 + i);
      wIss[k]   = ((i + pat) % 5) == 0;
      wNs[k]    = ((i * 3 + pat) % 4) == 1;
      wSrcV[k]  = 2'((i + pat) % 4);
      wSrcR[k]  = (((i + 2 * pat) % 3) == 0) ? 2'b01 : 2'b00;
      wTags[k]  = {6'((i * 11 + pat * 3 + 20) % 64), 6'((i * 7 + pat * 5) % 64)};
    end
  endtask

  // stopAfter = 0 runs to the natural end; poke sends a stray request mid-walk
  task automatic runWalk(int tail, int bnd, int stopAfter, bit poke);
    int eExam = 0, ePush = 0, eSum = 0, eNs = 0, eCan = 0, eTag = 0, eOps = 0;
    int aPush = 0, aSum = 0, aNs = 0, aCan = 0, aTag = 0, nsBad = 0;
    int cyc = 0, firstIdx = -1, doneSeen = 0, quietBad = 0;
    int cap = (stopAfter > 0) ? stopAfter : DEPTH;
    int pushed [$];
    int k = tail;
    int exam0 = expExam, ops0 = expOps, ns0 = expNs;
    while (eExam < cap && wValid[k] && int'(wSeq[k]) > bnd) begin
      eExam++;
      if (!wIss[k] && !wSq[k]) begin
        ePush++; eSum += ePush * (k + 1);
        if (wNs[k]) eNs++;
        else for (int s = 0; s < NSRC; s++) if (wSrcV[k][s]) begin
          int tg = int'(wTags[k][s*TAG_W +: TAG_W]);
          eOps++;
          if (!wSrcR[k][s] && tg < PHYS) begin eCan++; eTag += tg; end
        end
      end
      k = (k == 0) ? DEPTH - 1 : k - 1;
    end
    expExam += eExam; expOps += eOps; expNs += eNs;

    @(negedge clk);
    squashReq = 1'b1; squashSeq = SEQ_W'(bnd); tailIdx = IDX_W'(tail);
    @(negedge clk);
    squashReq = 1'b0;
    for (int t = 0; t < 40 && (busy || t == 0); t++) begin
      if (t > 0) @(negedge clk);
      if (!busy) break;
      if (stopAfter > 0 && cyc == stopAfter) begin
        stopSquash = 1'b1;
        #0.5;
        if (pushValid || nsRemValid || cancelValid != '0) quietBad++;
        @(negedge clk);
        stopSquash = 1'b0;
        break;
      end
      cyc++;
      if (firstIdx < 0) firstIdx = int'(rdIdx);
      if (poke && cyc == 1) begin
        squashReq = 1'b1; squashSeq = 16'd1; tailIdx = IDX_W'(tail ^ 1);
      end else squashReq = 1'b0;
      if (pushValid) begin
        aPush++; aSum += aPush * (int'(pushIdx) + 1); pushed.push_back(int'(pushIdx));
      end
      if (nsRemValid) begin
        aNs++;
        if (nsRemSeq != wSeq[rdIdx]) nsBad++;
      end
      for (int s = 0; s < NSRC; s++) if (cancelValid[s]) begin
        aCan++; aTag += int'(cancelTags[s*TAG_W +: TAG_W]);
      end
    end
    squashReq = 1'b0;
    if (stopAfter == 0) begin
      check("R2 first index is tail", firstIdx, tail);
      check("R4 busy cycles", cyc, eExam + 1);
      doneSeen = done;
      @(negedge clk);
      check("R4 done pulse width", doneSeen * 10 + int'(done), 10);
    end else begin
      check("R8 stop busy cycles", cyc, eExam);
      check("R8 stop quiet/busy/done", quietBad * 100 + int'(busy) * 10 + int'(done), 0);
    end
    check("R6 push count", aPush, ePush);
    check("R3 R6 push order", aSum, eSum);
    check("R7 ns removals", aNs * 100 + nsBad, eNs * 100);
    check("R6 cancels", aCan * 1000 + aTag, eCan * 1000 + eTag);
    check("R9 examined", int'(cntExamined), (exam0 + eExam) % 65536);
    check("R9 operands", int'(cntOperands), (ops0 + eOps) % 65536);
    check("R9 ns removed", int'(cntNsRemoved), (ns0 + eNs) % 65536);
    foreach (pushed[j]) wSq[pushed[j]] = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fill(0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", int'({busy, done, pushValid, nsRemValid, cancelValid}), 0);
    check("R1 reset counters", int'(cntExamined) + int'(cntOperands) + int'(cntNsRemoved), 0);

    // R2: zero boundary is ignored
    fill(2, 6, 0);
    squashReq = 1'b1; squashSeq = '0; tailIdx = 3'd7;
    @(negedge clk);
    squashReq = 1'b0;
    check("R2 zero boundary ignored", int'(busy), 0);
    @(negedge clk);
    check("R2 zero boundary no done", int'(done), 0);

    // main sweep, each walk repeated so squashed entries are stepped over (R5)
    for (int pat = 0; pat < 3; pat++)
      for (int h = 0; h < 3; h++)
        for (int c = 0; c < 2; c++) begin
          int head = h * 3;
          int count = (c == 0) ? 5 : DEPTH;
          for (int bnd = 9; bnd <= 10 + count; bnd++) begin
            fill(head, count, pat);
            runWalk((head + count - 1) % DEPTH, bnd, 0, pat == 1);
            runWalk((head + count - 1) % DEPTH, bnd, 0, 1'b0);
          end
        end

    // R8: stop mid-walk, then a fresh walk
    fill(4, DEPTH, 2);
    runWalk(3, 9, 3, 1'b0);
    runWalk(3, 9, 0, 1'b0);

    // R8: stop beats a simultaneous request
    fill(1, 5, 1);
    @(negedge clk);
    squashReq = 1'b1; stopSquash = 1'b1; squashSeq = 16'd9; tailIdx = 3'd5;
    @(negedge clk);
    squashReq = 1'b0; stopSquash = 1'b0;
    check("R8 stop priority over request", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule